// File: doc/BRIEF.md
# Dual-Oscillator Challenge-Response Engine

This engine turns a challenge word into one response bit by racing two free-running oscillators. A challenge is decoded into a single column enable and two groups of row addresses, one group per oscillator. The external array uses these selects to set the speed of each oscillator. The engine first waits a fixed settle interval so that the oscillators can stabilise. It then opens a fixed gate window in which it counts rising edges from both oscillators. At the end of the window the two counts are compared, which gives one bit.

A set of challenges is applied one after another, and the bits are concatenated into a wide response word. The word is presented with a single-cycle valid strobe once the last challenge of the set has been measured. The engine works only while the phase input is low. Raising the phase input, which marks array programming, stops any measurement and discards any partial set.

Top module: `puf_resp_engine`

## Requirements
- R1: `chal_ready` is high exactly when the engine is idle and `prog_phase` is low. A challenge is taken on a clock edge where `chal_valid` and `chal_ready` are both high.
- R2: During a measurement, `col_en` is the one-hot decode of challenge bits `[CIW-1:0]`, where CIW = log2(N_COLS). At all other times `col_en` is all zeros, and it never has more than one bit set.
- R3: During a measurement, `rows_a` equals challenge bits `[CIW +: STAGES*RIW]` and `rows_b` equals the next STAGES*RIW bits, where RIW = log2(N_ROWS). These outputs change only on the edge where a challenge is accepted.
- R4: After a challenge is accepted, `chal_ready` stays low for exactly SETTLE_CYC + GATE_CYC + 1 cycles: the settle interval, the gate window and one compare cycle. Both edge counters are cleared at the start of the gate.
- R5: Each oscillator input passes through a two-flop synchroniser, and its rising edges are counted only within the gate window. The response bit is 1 when the count for oscillator A is greater than the count for oscillator B, and 0 otherwise. A tie, including the case where both oscillators are stopped, gives 0.
- R6: The response bits of a set of N_CHAL challenges are shifted in LSB-first. Bit i of `resp_word` is the response to the i-th challenge of the set, counting from 0.
- R7: `resp_valid` is a one-cycle pulse. It rises on the same edge at which `chal_ready` returns high after the last challenge of a set, and it is low at all other times.
- R8: While `prog_phase` is high, `chal_ready` and `col_en` are low. If `prog_phase` rises during a measurement, that measurement and every bit already gathered for the set are discarded, so the next response word contains only challenges applied afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_phase | input | 1 | High while the array is being programmed; the engine is held idle |
| chal_valid | input | 1 | A challenge is offered |
| chal_data | input | CIW+2*STAGES*RIW | Challenge word: column index, then A row addresses, then B row addresses |
| chal_ready | output | 1 | Engine can take a challenge |
| osc_a | input | 1 | Oscillator A output, asynchronous |
| osc_b | input | 1 | Oscillator B output, asynchronous |
| col_en | output | N_COLS | One-hot column enable |
| rows_a | output | STAGES*RIW | Row addresses feeding oscillator A |
| rows_b | output | STAGES*RIW | Row addresses feeding oscillator B |
| resp_valid | output | 1 | One-cycle strobe marking a complete response word |
| resp_word | output | N_CHAL | Concatenated response bits, first challenge in bit 0 |

## Verification
The bench drives the oscillators as bench clocks whose half-periods change from one challenge to the next, and it picks at random which of the two is faster. The word it expects then shows whether the comparison direction and the LSB-first bit order are right. Directed challenges cover the cases that separate strict from non-strict comparison: both oscillators stopped, which must give 0 on the tie, and only one oscillator running. The lowest and highest column indices and randomised row fields check that the select decode is correct. An abort in the middle of a set, made by raising the phase input, checks that partial results are thrown away and do not leak into the next word.

// File: rtl/puf_eng_pkg.sv
`timescale 1ns/1ps
package puf_eng_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_GATE   = 2'd2,
        ST_CMP    = 2'd3
    } eng_state_e;
endpackage

// File: rtl/osc_edge_sync.sv
`timescale 1ns/1ps
module osc_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_in,
    output logic rise_o
);
    logic [2:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[1:0], osc_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    // pipe_q[0..1] form the two-flop synchroniser; pipe_q[2] holds the previous sample
    assign rise_o = pipe_q[1] & ~pipe_q[2];
endmodule

// File: rtl/edge_counter.sv
`timescale 1ns/1ps
module edge_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> (cnt_q != {CNT_W{1'b1}}));
endmodule

// File: rtl/col_decoder.sv
`timescale 1ns/1ps
module col_decoder #(
    parameter int N_COLS = 16,
    parameter int CIW    = 4
) (
    input  logic [CIW-1:0]    idx,
    input  logic              en,
    output logic [N_COLS-1:0] onehot
);
    for (genvar c = 0; c < N_COLS; c++) begin : g_col
        assign onehot[c] = en && (idx == CIW'(c));
    end
endmodule

// File: rtl/puf_resp_engine.sv
`timescale 1ns/1ps
module puf_resp_engine #(
    parameter int N_COLS     = 16,
    parameter int N_ROWS     = 32,
    parameter int STAGES     = 5,
    parameter int N_CHAL     = 128,
    parameter int SETTLE_CYC = 64,
    parameter int GATE_CYC   = 1024,
    localparam int CIW       = $clog2(N_COLS),
    localparam int RIW       = $clog2(N_ROWS),
    localparam int GRPW      = STAGES * RIW,
    localparam int CHAL_W    = CIW + 2 * GRPW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_phase,
    input  logic              chal_valid,
    input  logic [CHAL_W-1:0] chal_data,
    output logic              chal_ready,
    input  logic              osc_a,
    input  logic              osc_b,
    output logic [N_COLS-1:0] col_en,
    output logic [GRPW-1:0]   rows_a,
    output logic [GRPW-1:0]   rows_b,
    output logic              resp_valid,
    output logic [N_CHAL-1:0] resp_word
);
    import puf_eng_pkg::*;

    localparam int CNT_W   = $clog2(GATE_CYC + 2);
    localparam int TMR_MAX = (SETTLE_CYC > GATE_CYC) ? SETTLE_CYC : GATE_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int IDX_W   = $clog2(N_CHAL + 1);

    typedef struct packed {
        eng_state_e        state;
        logic [TMR_W-1:0]  tmr;
        logic [CIW-1:0]    col;
        logic [GRPW-1:0]   ra;
        logic [GRPW-1:0]   rb;
        logic [IDX_W-1:0]  idx;
        logic [N_CHAL-1:0] shift;
        logic              rvalid;
    } eng_regs_t;

    eng_regs_t r_d, r_q;

    logic             rise_a, rise_b;
    logic [CNT_W-1:0] cnt_a, cnt_b;
    logic             meas_on, gate_on, resp_bit;

    osc_edge_sync i_sync_a (.clk(clk), .rst_n(rst_n), .osc_in(osc_a), .rise_o(rise_a));
    osc_edge_sync i_sync_b (.clk(clk), .rst_n(rst_n), .osc_in(osc_b), .rise_o(rise_b));

    assign gate_on = (r_q.state == ST_GATE);

    edge_counter #(.CNT_W(CNT_W)) i_cnt_a (
        .clk(clk), .rst_n(rst_n), .clr(!gate_on), .inc(gate_on && rise_a), .count_o(cnt_a));
    edge_counter #(.CNT_W(CNT_W)) i_cnt_b (
        .clk(clk), .rst_n(rst_n), .clr(!gate_on), .inc(gate_on && rise_b), .count_o(cnt_b));

    assign meas_on  = !prog_phase && ((r_q.state == ST_SETTLE) || gate_on);
    assign resp_bit = (cnt_a > cnt_b);

    col_decoder #(.N_COLS(N_COLS), .CIW(CIW)) i_col_dec (
        .idx(r_q.col), .en(meas_on), .onehot(col_en));

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        if (prog_phase) begin
            r_d.state = ST_IDLE;
            r_d.tmr   = '0;
            r_d.idx   = '0;
            r_d.shift = '0;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (chal_valid) begin
                        r_d.state = ST_SETTLE;
                        r_d.tmr   = '0;
                        r_d.col   = chal_data[CIW-1:0];
                        r_d.ra    = chal_data[CIW +: GRPW];
                        r_d.rb    = chal_data[CIW + GRPW +: GRPW];
                    end
                end
                ST_SETTLE: begin
                    if (r_q.tmr == TMR_W'(SETTLE_CYC - 1)) begin
                        r_d.state = ST_GATE;
                        r_d.tmr   = '0;
                    end else begin
                        r_d.tmr = r_q.tmr + 1'b1;
                    end
                end
                ST_GATE: begin
                    if (r_q.tmr == TMR_W'(GATE_CYC - 1)) begin
                        r_d.state = ST_CMP;
                        r_d.tmr   = '0;
                    end else begin
                        r_d.tmr = r_q.tmr + 1'b1;
                    end
                end
                ST_CMP: begin
                    r_d.state = ST_IDLE;
                    r_d.shift = (r_q.shift >> 1) | (N_CHAL'(resp_bit) << (N_CHAL - 1));
                    if (r_q.idx == IDX_W'(N_CHAL - 1)) begin
                        r_d.idx    = '0;
                        r_d.rvalid = 1'b1;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, tmr: '0, col: '0, ra: '0, rb: '0,
                     idx: '0, shift: '0, rvalid: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign chal_ready = (r_q.state == ST_IDLE) && !prog_phase;
    assign rows_a     = r_q.ra;
    assign rows_b     = r_q.rb;
    assign resp_valid = r_q.rvalid;
    assign resp_word  = r_q.shift;

    // R2
    col_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_en));

    // R2
    col_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chal_ready |-> (col_en == '0));

    // R3
    rows_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(chal_valid && chal_ready) |=> ($stable(rows_a) && $stable(rows_b)));

    // R4
    busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chal_valid && chal_ready) |=> !chal_ready);

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R8
    phase_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_phase |-> (!chal_ready && (col_en == '0)));
endmodule

// File: tb/test_puf_resp_engine.sv
`timescale 1ns/1ps
module test_puf_resp_engine;
    localparam int N_COLS = 16;
    localparam int N_ROWS = 32;
    localparam int STAGES = 5;
    localparam int N_CHAL = 8;
    localparam int SETTLE = 16;
    localparam int GATE   = 200;
    localparam int CIW    = $clog2(N_COLS);
    localparam int RIW    = $clog2(N_ROWS);
    localparam int GRPW   = STAGES * RIW;
    localparam int CW     = CIW + 2 * GRPW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              prog_phase = 1'b0;
    logic              chal_valid = 1'b0;
    logic [CW-1:0]     chal_data = '0;
    logic              chal_ready;
    logic              osc_a = 1'b0;
    logic              osc_b = 1'b0;
    logic [N_COLS-1:0] col_en;
    logic [GRPW-1:0]   rows_a, rows_b;
    logic              resp_valid;
    logic [N_CHAL-1:0] resp_word;

    int ha = 0;
    int hb = 0;
    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    puf_resp_engine #(
        .N_COLS(N_COLS), .N_ROWS(N_ROWS), .STAGES(STAGES), .N_CHAL(N_CHAL),
        .SETTLE_CYC(SETTLE), .GATE_CYC(GATE)
    ) i_puf_resp_engine (
        .clk(clk), .rst_n(rst_n), .prog_phase(prog_phase),
        .chal_valid(chal_valid), .chal_data(chal_data), .chal_ready(chal_ready),
        .osc_a(osc_a), .osc_b(osc_b), .col_en(col_en),
        .rows_a(rows_a), .rows_b(rows_b),
        .resp_valid(resp_valid), .resp_word(resp_word)
    );

    always #2 clk = ~clk;

    initial forever begin
        if (ha == 0) #3;
        else begin #(ha) osc_a = ~osc_a; end
    end
    initial forever begin
        if (hb == 0) #3;
        else begin #(hb) osc_b = ~osc_b; end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_bit(input int a, input int b);
        if (a == 0) return 1'b0;
        if (b == 0) return 1'b1;
        return a < b;
    endfunction

    function automatic logic [CW-1:0] rand_chal(input int col);
        logic [CW-1:0] c;
        c = CW'({$urandom, $urandom});
        if (col >= 0) c[CIW-1:0] = CIW'(col);
        return c;
    endfunction

    // Applies one challenge; returns the bit the requirements predict
    task automatic run_chal(input logic [CW-1:0] c, input int a, input int b,
                            input bit last, output bit eb);
        int lat;
        ha = a;
        hb = b;
        eb = exp_bit(a, b);
        @(negedge clk);
        while (!chal_ready) @(negedge clk);
        chal_data  = c;
        chal_valid = 1'b1;
        @(posedge clk);
        #1 chal_valid = 1'b0;
        @(negedge clk);
        chk(col_en == N_COLS'(1) << c[CIW-1:0], "R2", "column enable", 64'(col_en),
            64'(N_COLS'(1) << c[CIW-1:0]));
        chk(rows_a == c[CIW +: GRPW], "R3", "rows A", 64'(rows_a), 64'(c[CIW +: GRPW]));
        chk(rows_b == c[CIW+GRPW +: GRPW], "R3", "rows B", 64'(rows_b),
            64'(c[CIW+GRPW +: GRPW]));
        lat = 0;
        while (!chal_ready && lat < 4 * (SETTLE + GATE)) begin
            if (resp_valid) chk(1'b0, "R7", "early valid", 64'(1), 64'(0));
            lat++;
            @(negedge clk);
        end
        chk(lat == SETTLE + GATE + 1, "R4", "busy cycles", 64'(lat), 64'(SETTLE + GATE + 1));
        chk(col_en == '0, "R2", "idle column enable", 64'(col_en), 64'(0));
        chk(resp_valid == last, "R7", "valid at end", 64'(resp_valid), 64'(last));
    endtask

    task automatic check_word(input logic [N_CHAL-1:0] exp, input string tag);
        chk(resp_word == exp, "R6", tag, 64'(resp_word), 64'(exp));
        @(negedge clk);
        chk(resp_valid == 1'b0, "R7", "single pulse", 64'(resp_valid), 64'(0));
    endtask

    initial begin
        logic [N_CHAL-1:0] ew;
        bit eb;
        int base;
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(chal_ready == 1'b1, "R1", "ready after reset", 64'(chal_ready), 64'(1));
        chk(resp_valid == 1'b0, "R7", "valid after reset", 64'(resp_valid), 64'(0));
        chk(col_en == '0, "R2", "columns after reset", 64'(col_en), 64'(0));

        // R8: phase high blocks the engine
        prog_phase = 1'b1;
        chal_valid = 1'b1;
        chal_data  = rand_chal(3);
        repeat (3) @(negedge clk);
        chk(chal_ready == 1'b0, "R8", "ready in phase", 64'(chal_ready), 64'(0));
        chk(col_en == '0, "R8", "columns in phase", 64'(col_en), 64'(0));
        chal_valid = 1'b0;
        prog_phase = 1'b0;
        @(negedge clk);
        chk(chal_ready == 1'b1, "R1", "ready after phase", 64'(chal_ready), 64'(1));

        // Set 1: directed corners (R5) then random
        ew = '0;
        for (int i = 0; i < N_CHAL; i++) begin
            int a, b;
            case (i)
                0: begin a = 0;  b = 0;  end
                1: begin a = 12; b = 0;  end
                2: begin a = 0;  b = 12; end
                3: begin a = 10; b = 17; end
                4: begin a = 17; b = 10; end
                default: begin
                    base = 10 + int'($urandom_range(6));
                    if ($urandom_range(1) == 1) begin a = base; b = base + 6 + int'($urandom_range(4)); end
                    else begin b = base; a = base + 6 + int'($urandom_range(4)); end
                end
            endcase
            run_chal(rand_chal(i == 0 ? 0 : (i == 1 ? N_COLS - 1 : -1)), a, b,
                     i == N_CHAL - 1, eb);
            ew[i] = eb;
        end
        check_word(ew, "set 1 word");

        // R8: partial set then abort mid-measurement
        for (int i = 0; i < 3; i++) begin
            run_chal(rand_chal(-1), 10, 0, 1'b0, eb);
        end
        ha = 10; hb = 0;
        @(negedge clk);
        chal_data = rand_chal(5);
        chal_valid = 1'b1;
        @(posedge clk);
        #1 chal_valid = 1'b0;
        repeat (20) @(negedge clk);
        prog_phase = 1'b1;
        @(negedge clk);
        chk(col_en == '0, "R8", "columns on abort", 64'(col_en), 64'(0));
        chk(chal_ready == 1'b0, "R8", "ready on abort", 64'(chal_ready), 64'(0));
        prog_phase = 1'b0;
        @(negedge clk);
        chk(chal_ready == 1'b1, "R8", "idle after abort", 64'(chal_ready), 64'(1));

        // Set 2: fresh random set; word must not contain aborted bits
        for (int r = 0; r < 3; r++) begin
            ew = '0;
            for (int i = 0; i < N_CHAL; i++) begin
                int a, b;
                base = 10 + int'($urandom_range(6));
                if ($urandom_range(1) == 1) begin a = base; b = base + 6 + int'($urandom_range(4)); end
                else begin b = base; a = base + 6 + int'($urandom_range(4)); end
                run_chal(rand_chal(-1), a, b, i == N_CHAL - 1, eb);
                ew[i] = eb;
            end
            check_word(ew, "random set word");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule